// File: doc/BRIEF.md
# Sensor Register SPI Slave

This block is the serial register port of a sensor chip. A host exchanges 16-bit frames with it, most significant bit first. Each frame the host sends is a command (read or write, with a 14-bit address) or the data word that completes a write. The block works out its answer to every frame and returns that answer during the next frame. Each answer carries 14 data bits, a sticky transmission-error flag and an even parity bit.

SCK, SS_N and MOSI are synchronised into the system clock domain, and their edges are found there, so the whole block runs on one clock. A two-state controller (`ST_CMD`: waiting for a command; `ST_DATA`: waiting for the data word of a write) owns the register map. The map holds a read-only angle word with two alarm bits, a read-only gain word, a configuration register (interrupt mode and offset-loop break), an 8-bit power-on-reset disable register, and three command addresses: clear-error, software reset and no-operation. The transitions are `ST_CMD -> ST_DATA` on a valid write command to a writable address, `ST_DATA -> ST_CMD` at the end of any data frame (good or bad), and `ST_CMD -> ST_CMD` on all other frames. The angle, alarm and gain values come in as ports and are sampled when the read command that asks for them completes.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 SCK periods while SS_N is low. MOSI is sampled on each SCK falling edge, MSB first. MISO changes on each SCK rising edge and presents bit 15 first. MISO is driven low while SS_N is high.
- R2: In a command frame, bit 15 selects read (1) or write (0), bits 14:1 hold the address, and bit 0 makes the parity of all 16 bits even.
- R3: In every response frame, bits 15:2 hold the data, bit 1 holds the error flag as it stands after the previous frame was processed, and bit 0 makes the parity of all 16 bits even.
- R4: The response to frame N is shifted out during frame N+1. The first frame after reset returns 0x0000.
- R5: A write command to a writable address returns the old register content in the next frame. The frame after it is taken as data, with the value in bits 15:2. The frame after the data returns the new content.
- R6: The error flag sets when a frame has bad parity, when SS_N rises after a clock count other than 16, when a read targets an unmapped address, or when a write targets an address that is not writable. Such a frame returns zero data. The flag is sticky.
- R7: A read of address 0x3380 clears the error flag and returns 0x0000. The all-zero frame is a no-operation and returns zero data.
- R8: A write to address 0x3C00 is a software reset, and both of its responses carry zero data. If bit 2 of its data frame is 1, the configuration register, the power-on-reset register and the error flag are cleared. If that bit is 0, they are left unchanged.
- R9: A read of 0x3FFF returns the angle in data bits 9:0, the high-field alarm in data bit 10 and the low-field alarm in data bit 11, sampled when the read command frame ends.
- R10: A read of 0x3FF8 returns the gain value in data bits 5:0.
- R11: Register 0x3FF9 is read/write and resets to 0. Its data bit 0 drives cfg_int_mode and its data bit 1 drives cfg_loop_break. Register 0x3F22 is an 8-bit read/write register (data bits 7:0) that resets to 0. por_cell_off is high exactly while it holds 0x5A.
- R12: A data frame with bad parity or a wrong clock count sets the error flag, discards the write and returns the controller to waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| angle_in | input | 10 | Measured angle |
| alarm_lo | input | 1 | Field-too-weak alarm |
| alarm_hi | input | 1 | Field-too-strong alarm |
| gain_in | input | 6 | Gain control value |
| cfg_int_mode | output | 1 | Interrupt gate mode bit |
| cfg_loop_break | output | 1 | Offset loop break bit |
| por_cell_off | output | 1 | High while the reset-disable key is stored |

## Verification
The assertions assume that SCK changes only while SS_N is low and that each SCK level and each SS_N high gap lasts several system clocks. Under that assumption every edge is seen once, and MOSI is stable when the synchronised falling edge samples it. The bench drives every frame with a half period of six system clocks and a twelve-clock gap between frames. It holds the angle, alarm and gain inputs steady for the whole frame. Random frames mix valid and corrupted parity, short and long clock counts, and all mapped and unmapped addresses, and a model in the bench predicts each response.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [0:0] {
        ST_CMD  = 1'b0,
        ST_DATA = 1'b1
    } ctrl_state_t;

    localparam logic [13:0] ADR_NOP   = 14'h0000;
    localparam logic [13:0] ADR_CLEAR = 14'h3380;
    localparam logic [13:0] ADR_SRST  = 14'h3C00;
    localparam logic [13:0] ADR_ANGLE = 14'h3FFF;
    localparam logic [13:0] ADR_GAIN  = 14'h3FF8;
    localparam logic [13:0] ADR_CFG   = 14'h3FF9;
    localparam logic [13:0] ADR_POR   = 14'h3F22;

    localparam logic [7:0]  POR_KEY   = 8'h5A;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ss_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic ss_fall,
    output logic ss_rise,
    output logic ss_low,
    output logic mosi_s
);
    // bit 0: sck, bit 1: ss_n, bit 2: mosi
    localparam logic [2:0] IDLE_LVL = 3'b010;

    logic [2:0] stg [STAGES];
    logic [2:0] prev;
    logic [2:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_LVL;
            prev <= IDLE_LVL;
        end else begin
            stg[0] <= {mosi, ss_n, sck};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign cur      = stg[STAGES-1];
    assign sck_rise = ~prev[0] &  cur[0];
    assign sck_fall =  prev[0] & ~cur[0];
    assign ss_fall  =  prev[1] & ~cur[1];
    assign ss_rise  = ~prev[1] &  cur[1];
    assign ss_low   = ~cur[1];
    assign mosi_s   =  cur[2];

endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               ss_fall,
    input  logic               ss_low,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic [FRAME_W-1:0] rx_word,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               miso
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    logic [FRAME_W-1:0] tx_sh;
    logic               miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
        end else if (!ss_low) begin
            miso_q <= 1'b0;
        end else if (ss_fall) begin
            bit_cnt <= '0;
            tx_sh   <= tx_word;
            miso_q  <= tx_word[FRAME_W-1];
        end else begin
            if (sck_fall) begin
                rx_word <= {rx_word[FRAME_W-2:0], mosi_s};
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_rise) begin
                miso_q <= tx_sh[FRAME_W-1];
                tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
    import spi_reg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ANGLE_W = 10,
    parameter int GAIN_W  = 6,
    parameter int POR_W   = 8,
    localparam int CNT_W  = $clog2(FRAME_W + 2),
    localparam int ADDR_W = FRAME_W - 2,
    localparam int DATA_W = FRAME_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               alarm_lo,
    input  logic               alarm_hi,
    input  logic [GAIN_W-1:0]  gain_in,
    output logic [FRAME_W-1:0] resp_word,
    output logic               err_flag,
    output logic               expect_data,
    output logic               int_mode,
    output logic               loop_break,
    output logic [POR_W-1:0]   por_reg
);
    ctrl_state_t        state, nxt_state;
    logic [ADDR_W-1:0]  wr_addr;

    logic               frame_ok;
    logic               is_read;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  wdata;
    logic [DATA_W-1:0]  rd_val;
    logic               rd_hit;
    logic               wr_ok;
    logic [DATA_W-1:0]  nxt_data;
    logic               nxt_err;
    logic               do_write;
    logic               do_srst;

    assign frame_ok = (bit_cnt == CNT_W'(FRAME_W)) && !(^rx_word);
    assign is_read  = rx_word[FRAME_W-1];
    assign addr     = rx_word[FRAME_W-2:1];
    assign wdata    = rx_word[FRAME_W-1:2];

    // register read mux
    always_comb begin
        rd_val = '0;
        rd_hit = 1'b1;
        case (addr)
            ADR_ANGLE: begin
                rd_val[ANGLE_W-1:0] = angle_in;
                rd_val[ANGLE_W]     = alarm_hi;
                rd_val[ANGLE_W+1]   = alarm_lo;
            end
            ADR_GAIN:  rd_val[GAIN_W-1:0] = gain_in;
            ADR_CFG:   rd_val[1:0] = {loop_break, int_mode};
            ADR_POR:   rd_val[POR_W-1:0] = por_reg;
            ADR_SRST:  rd_val = '0;
            default:   rd_hit = 1'b0;
        endcase
        wr_ok = (addr == ADR_CFG) || (addr == ADR_POR) || (addr == ADR_SRST);
    end

    // next state and frame outcome
    always_comb begin
        nxt_state = state;
        nxt_err   = err_flag;
        nxt_data  = '0;
        do_write  = 1'b0;
        do_srst   = 1'b0;
        unique case (state)
            ST_CMD: begin
                if (!frame_ok) begin
                    nxt_err = 1'b1;
                end else if (is_read) begin
                    if (addr == ADR_CLEAR)   nxt_err = 1'b0;
                    else if (rd_hit && addr != ADR_SRST) nxt_data = rd_val;
                    else                     nxt_err = 1'b1;
                end else if (addr == ADR_NOP) begin
                    nxt_data = '0;
                end else if (wr_ok) begin
                    nxt_data  = rd_val;
                    nxt_state = ST_DATA;
                end else begin
                    nxt_err = 1'b1;
                end
            end
            ST_DATA: begin
                nxt_state = ST_CMD;
                if (!frame_ok) begin
                    nxt_err = 1'b1;
                end else if (wr_addr == ADR_SRST) begin
                    if (rx_word[2]) begin
                        do_srst = 1'b1;
                        nxt_err = 1'b0;
                    end
                end else begin
                    do_write = 1'b1;
                    if (wr_addr == ADR_CFG) nxt_data[1:0] = wdata[1:0];
                    else                    nxt_data[POR_W-1:0] = wdata[POR_W-1:0];
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state <= ST_CMD;
        else if (frame_done) state <= nxt_state;
    end

    // outputs and register bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_word  <= '0;
            err_flag   <= 1'b0;
            wr_addr    <= '0;
            int_mode   <= 1'b0;
            loop_break <= 1'b0;
            por_reg    <= '0;
        end else if (frame_done) begin
            resp_word <= {nxt_data, nxt_err, ^{nxt_data, nxt_err}};
            err_flag  <= nxt_err;
            if (state == ST_CMD) wr_addr <= addr;
            if (do_write && wr_addr == ADR_CFG) begin
                int_mode   <= wdata[0];
                loop_break <= wdata[1];
            end
            if (do_write && wr_addr == ADR_POR) por_reg <= wdata[POR_W-1:0];
            if (do_srst) begin
                int_mode   <= 1'b0;
                loop_break <= 1'b0;
                por_reg    <= '0;
            end
        end
    end

    assign expect_data = (state == ST_DATA);

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int ANGLE_W     = 10,
    parameter int GAIN_W      = 6,
    parameter int POR_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               ss_n,
    input  logic               mosi,
    output logic               miso,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               alarm_lo,
    input  logic               alarm_hi,
    input  logic [GAIN_W-1:0]  gain_in,
    output logic               cfg_int_mode,
    output logic               cfg_loop_break,
    output logic               por_cell_off
);
    logic               sck_rise, sck_fall, ss_fall, frame_done, in_frame, mosi_s;
    logic [FRAME_W-1:0] rx_word, resp_word;
    logic [CNT_W-1:0]   bit_cnt;
    logic               err_flag, expect_data;
    logic [POR_W-1:0]   por_reg;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .ss_n     (ss_n),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ss_fall  (ss_fall),
        .ss_rise  (frame_done),
        .ss_low   (in_frame),
        .mosi_s   (mosi_s)
    );

    spi_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ss_fall  (ss_fall),
        .ss_low   (in_frame),
        .mosi_s   (mosi_s),
        .tx_word  (resp_word),
        .rx_word  (rx_word),
        .bit_cnt  (bit_cnt),
        .miso     (miso)
    );

    spi_reg_ctrl #(
        .FRAME_W (FRAME_W),
        .ANGLE_W (ANGLE_W),
        .GAIN_W  (GAIN_W),
        .POR_W   (POR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .bit_cnt     (bit_cnt),
        .rx_word     (rx_word),
        .angle_in    (angle_in),
        .alarm_lo    (alarm_lo),
        .alarm_hi    (alarm_hi),
        .gain_in     (gain_in),
        .resp_word   (resp_word),
        .err_flag    (err_flag),
        .expect_data (expect_data),
        .int_mode    (cfg_int_mode),
        .loop_break  (cfg_loop_break),
        .por_reg     (por_reg)
    );

    assign por_cell_off = (por_reg == POR_KEY);

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int FRAME_W = 16,
    parameter int POR_W   = 8,
    localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_done,
    input logic [CNT_W-1:0]   bit_cnt,
    input logic [FRAME_W-1:0] resp_word,
    input logic               err_flag,
    input logic               in_frame,
    input logic               miso,
    input logic               expect_data,
    input logic               cfg_int_mode,
    input logic               cfg_loop_break,
    input logic [POR_W-1:0]   por_reg
);
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> !miso); // R1

    AST_RESP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (^resp_word) == 1'b0); // R3

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(resp_word)); // R4

    AST_DATA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expect_data) |-> $past(frame_done)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !frame_done |=> err_flag); // R6

    AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && bit_cnt != CNT_W'(FRAME_W) |=> err_flag); // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable({cfg_int_mode, cfg_loop_break, por_reg})); // R11

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.FRAME_W(FRAME_W), .POR_W(POR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_done     (frame_done),
    .bit_cnt        (bit_cnt),
    .resp_word      (resp_word),
    .err_flag       (err_flag),
    .in_frame       (in_frame),
    .miso           (miso),
    .expect_data    (expect_data),
    .cfg_int_mode   (cfg_int_mode),
    .cfg_loop_break (cfg_loop_break),
    .por_reg        (por_reg)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;

    localparam int HALF = 6;
    localparam int GAP  = 12;

    localparam logic [13:0] A_CLR = 14'h3380, A_SRST = 14'h3C00, A_ANG = 14'h3FFF,
                            A_GAIN = 14'h3FF8, A_CFG = 14'h3FF9, A_POR = 14'h3F22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [9:0] angle_in = '0;
    logic alarm_lo = 1'b0, alarm_hi = 1'b0;
    logic [5:0] gain_in = '0;
    logic cfg_int_mode, cfg_loop_break, por_cell_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [15:0] m_resp = '0;
    logic        m_err = 1'b0, m_data = 1'b0, m_int = 1'b0, m_brk = 1'b0;
    logic [13:0] m_waddr = '0;
    logic [7:0]  m_por = '0;

    always #4 clk = ~clk;

    spi_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
        .angle_in(angle_in), .alarm_lo(alarm_lo), .alarm_hi(alarm_hi), .gain_in(gain_in),
        .cfg_int_mode(cfg_int_mode), .cfg_loop_break(cfg_loop_break), .por_cell_off(por_cell_off)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] cmd(input logic rd, input logic [13:0] a, input logic bad);
        logic [15:0] w;
        w = {rd, a, 1'b0};
        w[0] = (^w[15:1]) ^ bad;
        return w;
    endfunction

    function automatic logic [15:0] dat(input logic [13:0] d, input logic bad);
        logic [15:0] w;
        w = {d, 2'b00};
        w[0] = (^w[15:1]) ^ bad;
        return w;
    endfunction

    function automatic logic [13:0] m_read(input logic [13:0] a, output logic hit);
        hit = 1'b1;
        case (a)
            A_ANG:  return {2'b00, alarm_lo, alarm_hi, angle_in};
            A_GAIN: return {8'h00, gain_in};
            A_CFG:  return {12'h000, m_brk, m_int};
            A_POR:  return {6'h00, m_por};
            default: begin hit = 1'b0; return '0; end
        endcase
    endfunction

    task automatic m_update(input logic [15:0] w, input int nclk);
        logic good, hit;
        logic [13:0] a, d, rv;
        good = (nclk == 16) && !(^w);
        a = w[14:1];
        d = '0;
        if (!m_data) begin
            rv = m_read(a, hit);
            if (!good) m_err = 1'b1;
            else if (w[15]) begin
                if (a == A_CLR) m_err = 1'b0;
                else if (hit) d = rv;
                else m_err = 1'b1;
            end else if (a == 14'h0) d = '0;
            else if (a == A_CFG || a == A_POR || a == A_SRST) begin
                d = (a == A_SRST) ? 14'h0 : rv;
                m_data = 1'b1;
                m_waddr = a;
            end else m_err = 1'b1;
        end else begin
            m_data = 1'b0;
            if (!good) m_err = 1'b1;
            else if (m_waddr == A_SRST) begin
                if (w[2]) begin m_err = 1'b0; m_int = 1'b0; m_brk = 1'b0; m_por = '0; end
            end else if (m_waddr == A_CFG) begin
                m_int = w[2]; m_brk = w[3]; d = {12'h0, w[3:2]};
            end else begin
                m_por = w[9:2]; d = {6'h0, w[9:2]};
            end
        end
        m_resp = {d, m_err, ^{d, m_err}};
    endtask

    task automatic xfer(input logic [15:0] w, input int nclk, input string tag);
        logic [15:0] got, mask, exp;
        got = '0;
        mask = '0;
        exp = m_resp;
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sck = 1'b1;
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) begin
                got[15-i] = miso;
                mask[15-i] = 1'b1;
            end
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        ss_n = 1'b1;
        repeat (GAP) @(negedge clk);
        check(tag, 32'(got & mask), 32'(exp & mask));
        m_update(w, nclk);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        check("R11 reset int_mode", 32'(cfg_int_mode), 0);
        check("R11 reset loop_break", 32'(cfg_loop_break), 0);
        check("R11 reset por_cell_off", 32'(por_cell_off), 0);
        check("R1 reset miso", 32'(miso), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        angle_in = 10'h2A5; alarm_lo = 1'b1; alarm_hi = 1'b0; gain_in = 6'h21;
        xfer(16'h0000, 16, "R4 first frame zero / R7 nop");
        xfer(cmd(1'b1, A_ANG, 1'b0), 16, "R2 read cmd");
        xfer(cmd(1'b1, A_GAIN, 1'b0), 16, "R9 angle data");
        xfer(16'h0000, 16, "R10 gain data");
        check("R1 miso idle", 32'(miso), 0);
        xfer(cmd(1'b0, A_CFG, 1'b0), 16, "R5 write cmd");
        xfer(dat(14'h3, 1'b0), 16, "R5 old content");
        xfer(16'h0000, 16, "R5 new content");
        check("R11 int_mode", 32'(cfg_int_mode), 1);
        check("R11 loop_break", 32'(cfg_loop_break), 1);
        xfer(cmd(1'b0, A_POR, 1'b0), 16, "R11 por write cmd");
        xfer(dat(14'h5A, 1'b0), 16, "R11 por old");
        check("R11 por_cell_off", 32'(por_cell_off), 1);
        xfer(cmd(1'b1, A_ANG, 1'b1), 16, "R11 por new");
        xfer(16'h0000, 16, "R6 bad parity response");
        xfer(cmd(1'b1, A_CLR, 1'b0), 16, "R6 sticky error");
        xfer(16'h0000, 15, "R7 clear returns zero");
        xfer(cmd(1'b1, A_CLR, 1'b0), 16, "R6 short frame");
        xfer(16'h0000, 17, "R7 clear");
        xfer(cmd(1'b1, A_CLR, 1'b0), 16, "R6 long frame");
        xfer(cmd(1'b1, 14'h1234, 1'b0), 16, "R7 clear");
        xfer(cmd(1'b0, A_ANG, 1'b0), 16, "R6 unmapped read");
        xfer(cmd(1'b1, A_CLR, 1'b0), 16, "R6 read-only write");
        xfer(cmd(1'b0, A_CFG, 1'b0), 16, "R7 clear");
        xfer(dat(14'h0, 1'b1), 16, "R12 old cfg");
        xfer(cmd(1'b1, A_CFG, 1'b0), 16, "R12 bad data frame");
        xfer(cmd(1'b0, A_SRST, 1'b0), 16, "R12 cfg kept");
        check("R12 int_mode kept", 32'(cfg_int_mode), 1);
        xfer(dat(14'h0, 1'b0), 16, "R8 srst cmd zero");
        xfer(cmd(1'b1, A_CFG, 1'b0), 16, "R8 srst data zero");
        check("R8 keep int_mode", 32'(cfg_int_mode), 1);
        xfer(cmd(1'b0, A_SRST, 1'b0), 16, "R8 cfg kept");
        xfer(dat(14'h1, 1'b0), 16, "R8 srst cmd zero");
        check("R8 cleared int_mode", 32'(cfg_int_mode), 0);
        check("R8 cleared por", 32'(por_cell_off), 0);
        xfer(cmd(1'b1, A_POR, 1'b0), 16, "R8 response after reset");
        xfer(16'h0000, 16, "R8 por zero");

        for (int n = 0; n < 260; n++) begin
            logic [13:0] a;
            int pick, nclk;
            logic [15:0] w;
            pick = int'($urandom_range(0, 7));
            case (pick)
                0: a = A_ANG; 1: a = A_GAIN; 2: a = A_CFG; 3: a = A_POR;
                4: a = A_CLR; 5: a = A_SRST; 6: a = 14'h0;
                default: a = 14'($urandom);
            endcase
            angle_in = 10'($urandom); alarm_lo = 1'($urandom); alarm_hi = 1'($urandom);
            gain_in = 6'($urandom);
            nclk = ($urandom_range(0, 19) == 0) ? int'($urandom_range(14, 17)) : 16;
            if (m_data) w = dat(14'($urandom), $urandom_range(0, 9) == 0);
            else        w = cmd(1'($urandom), a, $urandom_range(0, 9) == 0);
            xfer(w, nclk, "R6 R5 random frame");
        end
        check("R11 random int_mode", 32'(cfg_int_mode), 32'(m_int));
        check("R11 random por_cell_off", 32'(por_cell_off), 32'(m_por == 8'h5A));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule